// File: doc/BRIEF.md
# Motor Speed Error Detector

This block measures how long a motor takes between tachometer events and compares that time with a programmed reference period. When the motor is early, it raises a too-fast enable. When it is late, it raises a too-slow enable. The width of each enable equals the timing difference in clock cycles. An external loop filter uses these enables to charge or discharge its integrator, and that sets the motor current.

The tachometer has two possible sources:
- **Internal:** the block counts toggles of a zero-crossing flag and flips its tachometer once per mechanical revolution, using a pole count chosen from a 2-bit code.
- **Sector:** an asynchronous external sector pulse input is resynchronised and used instead.

Each falling edge of the selected tachometer restarts the reference count. A start-up pull-up request stays active until the first too-fast result. A sync status shows when a reference count is in progress, and a change of tachometer source waits until that status is low. An external-speed-control mode silences both error enables but leaves the start-up release working.

Top module: `speed_error_detector`

## Requirements
- R1: In internal mode the tachometer level flips once for every (poles × 3) toggles of the zero-crossing flag.
- R2: The pole code is decoded as 2'b00 → 8 poles, 2'b01 → 4, 2'b10 → 16, 2'b11 → 12.
- R3: The reference period in cycles is the sum of 16·2^i over every bit i of the 14-bit reference word that is 0 (active low).
- R4: A tachometer falling edge restarts the reference count. Sync status is high from that edge until the count reaches the period, and low before the first edge and after expiry.
- R5: If the next tachometer falling edge comes e cycles after the previous one with e < period, err_fast is high for exactly period − e cycles.
- R6: If e > period, err_slow is high for exactly e − period cycles, from the reference end up to that edge. If e = period, neither error is raised.
- R7: The pull-up request is high after reset and falls when the first too-fast result is produced. It then stays low until reset.
- R8: With the sector source selected, falling edges of the sector input, after a two-flop synchroniser, are the tachometer events, and zero-crossing toggles have no effect.
- R9: A change of the source-select input takes effect only while sync status is low. A sector edge that arrives while a count runs under the internal source is ignored.
- R10: With external speed control selected, err_fast and err_slow stay low, while the pull-up release of R7 still occurs.
- R11: Synchronous active-low reset clears both errors, clears sync status and sets the pull-up request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zc_flag | input | 1 | Zero-crossing flag, toggles once per crossing (synchronous) |
| sector_in | input | 1 | External sector pulse, asynchronous |
| pole_code | input | 2 | Pole-count select |
| ref_word_n | input | 14 | Active-low reference period word |
| use_sector | input | 1 | 1 selects the sector input as tachometer |
| ext_speed | input | 1 | 1 disables the error enables |
| err_fast | output | 1 | Too-fast enable (discharge filter) |
| err_slow | output | 1 | Too-slow enable (charge filter) |
| pullup_req | output | 1 | Start-up pull-up request |
| sync_status | output | 1 | Reference count in progress |
| tach_out | output | 1 | Selected tachometer level |

## Verification
The hardest situation to reach is a request to change source while a reference count runs, because sync status is high only in the window between a tachometer edge and expiry. The stimulus first starts a long reference with internal toggles. It then raises the source select and drives a sector falling edge inside that window, where nothing must happen. It then waits past expiry so that the deferred switch completes, and shows that the next sector edge restarts the count. The pulse widths are measured by counting high cycles over a window, so each pole code and each weight of the reference word shows up directly in the counts.

// File: rtl/speed_pkg.sv
// Shared types and decoders for the speed error detector.
// Assumes the pole code and reference word are quasi-static configuration.
package speed_pkg;

    typedef enum logic [1:0] {
        REF_IDLE = 2'd0,
        REF_RUN  = 2'd1,
        REF_LATE = 2'd2
    } ref_state_t;

    // Zero-crossing toggles per mechanical revolution (poles x 3).
    function automatic logic [5:0] toggles_per_rev(input logic [1:0] code);
        case (code)
            2'b00:   return 6'd24;
            2'b01:   return 6'd12;
            2'b10:   return 6'd48;
            default: return 6'd36;
        endcase
    endfunction

endpackage

// File: rtl/tach_divider.sv
// Internal tachometer: counts zero-crossing flag toggles and flips the
// tach level once per mechanical revolution. Assumes zc_flag is synchronous.
module tach_divider #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zc_flag,
    input  logic [1:0] pole_code,
    output logic       tach
);
    import speed_pkg::*;

    logic             zc_prev;
    logic             zc_toggle;
    logic [CNT_W-1:0] tog_cnt;
    logic [CNT_W-1:0] wrap_at;

    assign zc_toggle = zc_flag ^ zc_prev;
    assign wrap_at   = CNT_W'(toggles_per_rev(pole_code) - 6'd1);

    // Track toggles and flip tach at the end of each revolution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zc_prev <= 1'b0;
            tog_cnt <= '0;
            tach    <= 1'b0;
        end else begin
            zc_prev <= zc_flag;
            if (zc_toggle) begin
                if (tog_cnt >= wrap_at) begin
                    tog_cnt <= '0;
                    tach    <= ~tach;
                end else begin
                    tog_cnt <= tog_cnt + CNT_W'(1);
                end
            end
        end
    end

    // Tach only moves on a toggle of the zero-crossing flag.
    assert_tach_on_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !zc_toggle |=> $stable(tach));

endmodule

// File: rtl/sector_sync.sv
// Multi-flop synchroniser for the asynchronous sector pulse input.
// Assumes the pulse is wider than STAGES clock cycles.
module sector_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First capture flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Following resolution flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/ref_error_timer.sv
// Reference period counter and lead/lag error pulse generator.
// A tach event restarts the count; an early event loads a too-fast pulse of
// the remaining length, and expiry raises too-slow until the next event.
module ref_error_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tach_event,
    input  logic [CNT_W-1:0] period,
    output logic             fast_on,
    output logic             slow_on,
    output logic             running,
    output logic             pullup_req
);
    import speed_pkg::*;

    ref_state_t       state;
    logic [CNT_W-1:0] ref_cnt;
    logic [CNT_W-1:0] fast_cnt;
    logic             fast_load;

    assign fast_load = tach_event && (state == REF_RUN) && (ref_cnt < period);

    // Reference sequencing: restart on event, expire into the late state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= REF_IDLE;
            ref_cnt <= '0;
        end else if (tach_event) begin
            state   <= REF_RUN;
            ref_cnt <= CNT_W'(1);
        end else if (state == REF_RUN) begin
            if (ref_cnt >= period) state <= REF_LATE;
            else                   ref_cnt <= ref_cnt + CNT_W'(1);
        end
    end

    // Too-fast pulse width counter: load lead time, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n)                fast_cnt <= '0;
        else if (fast_load)        fast_cnt <= period - ref_cnt;
        else if (fast_cnt != '0)   fast_cnt <= fast_cnt - CNT_W'(1);
    end

    // Start-up pull-up request, released by the first too-fast result.
    always_ff @(posedge clk) begin
        if (!rst_n)         pullup_req <= 1'b1;
        else if (fast_load) pullup_req <= 1'b0;
    end

    assign fast_on = (fast_cnt != '0);
    assign slow_on = (state == REF_LATE);
    assign running = (state == REF_RUN);

    // Release follows the first too-fast load.
    assert_pullup_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fast_load |=> !pullup_req);
    // Once released, the request never returns before reset.
    assert_pullup_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pullup_req |=> !pullup_req);
    // Too-slow persists until a tach event ends it.
    assert_slow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_on && !tach_event) |=> slow_on);
    // An event always leaves the block counting.
    assert_event_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tach_event |=> running && !slow_on);

endmodule

// File: rtl/speed_error_detector.sv
// Top: selects the tachometer source, detects its falling edges and drives
// the reference timer. Source changes are deferred while a count runs.
// Assumes zc_flag is synchronous to clk; sector_in may be asynchronous.
module speed_error_detector #(
    parameter int REF_W      = 14,
    parameter int BASE_SHIFT = 4,
    parameter int SYNC_STG   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zc_flag,
    input  logic             sector_in,
    input  logic [1:0]       pole_code,
    input  logic [REF_W-1:0] ref_word_n,
    input  logic             use_sector,
    input  logic             ext_speed,
    output logic             err_fast,
    output logic             err_slow,
    output logic             pullup_req,
    output logic             sync_status,
    output logic             tach_out
);
    localparam int CNT_W    = REF_W + BASE_SHIFT;
    localparam int TOG_CNT_W = 6;

    logic             tach_int;
    logic             sec_sync;
    logic             active_src;
    logic             src_switch;
    logic             tach_sel;
    logic             tach_prev;
    logic             tach_event;
    logic             fast_on;
    logic             slow_on;
    logic             running;
    logic [CNT_W-1:0] period;

    assign period = {~ref_word_n, {BASE_SHIFT{1'b0}}};

    tach_divider #(.CNT_W(TOG_CNT_W)) i_tach_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .zc_flag   (zc_flag),
        .pole_code (pole_code),
        .tach      (tach_int)
    );

    sector_sync #(.STAGES(SYNC_STG)) i_sector_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sector_in),
        .sync_out (sec_sync)
    );

    assign src_switch = !running && (use_sector != active_src);
    assign tach_sel   = active_src ? sec_sync : tach_int;
    assign tach_event = !src_switch && tach_prev && !tach_sel;

    // Apply a source change only when no reference count is running.
    always_ff @(posedge clk) begin
        if (!rst_n)          active_src <= 1'b0;
        else if (src_switch) active_src <= use_sector;
    end

    // Edge history; reseeded from the new source on a switch.
    always_ff @(posedge clk) begin
        if (!rst_n)          tach_prev <= 1'b0;
        else if (src_switch) tach_prev <= use_sector ? sec_sync : tach_int;
        else                 tach_prev <= tach_sel;
    end

    ref_error_timer #(.CNT_W(CNT_W)) i_ref_error_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tach_event (tach_event),
        .period     (period),
        .fast_on    (fast_on),
        .slow_on    (slow_on),
        .running    (running),
        .pullup_req (pullup_req)
    );

    assign err_fast    = fast_on && !ext_speed;
    assign err_slow    = slow_on && !ext_speed;
    assign sync_status = running;
    assign tach_out    = tach_sel;

    // The selected source is frozen while a count is in progress.
    assert_src_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(active_src));

endmodule

// File: tb/test_speed_error_detector.sv
module test_speed_error_detector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        zc_flag = 1'b0;
    logic        sector_in = 1'b0;
    logic [1:0]  pole_code = 2'b00;
    logic [13:0] ref_word_n = '1;
    logic        use_sector = 1'b0;
    logic        ext_speed = 1'b0;
    logic        err_fast, err_slow, pullup_req, sync_status, tach_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cnt_fast = 0;
    int cnt_slow = 0;

    always #5 clk = ~clk;

    speed_error_detector i_speed_error_detector (
        .clk(clk), .rst_n(rst_n), .zc_flag(zc_flag), .sector_in(sector_in),
        .pole_code(pole_code), .ref_word_n(ref_word_n), .use_sector(use_sector),
        .ext_speed(ext_speed), .err_fast(err_fast), .err_slow(err_slow),
        .pullup_req(pullup_req), .sync_status(sync_status), .tach_out(tach_out)
    );

    // Vector table: source, pole code, reference multiple m (period 16*m),
    // spacing k (internal: cycles per toggle; sector: cycles between edges).
    localparam int NV = 9;
    localparam int V_SRC [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1};
    localparam int V_POLE[NV] = '{1, 1, 0, 2, 3, 0, 0, 0, 0};
    localparam int V_M   [NV] = '{10, 10, 6, 7, 8, 5, 4, 1024, 3};
    localparam int V_K   [NV] = '{4, 8, 2, 1, 2, 50, 100, 16000, 48};

    // R2: toggles per revolution from pole code.
    function automatic int rev_toggles(input int code);
        case (code)
            0: return 24;
            1: return 12;
            2: return 48;
            default: return 36;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (err_fast) cnt_fast++;
        if (err_slow) cnt_slow++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        cnt_fast = 0;
        cnt_slow = 0;
    endtask

    task automatic zc_burst(input int n, input int k);
        for (int i = 0; i < n; i++) begin
            repeat (k - 1) tick();
            zc_flag = ~zc_flag;
            tick();
        end
    endtask

    task automatic sector_fall_after(input int gap);
        repeat (gap - 3) tick();
        sector_in = 1'b1;
        repeat (3) tick();
        sector_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R11 actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R11: reset state.
        do_reset();
        check("R11 err_fast", err_fast, 0);
        check("R11 err_slow", err_slow, 0);
        check("R11 pullup", pullup_req, 1);
        check("R11 sync", sync_status, 0);

        // Table walk: R1/R2/R3/R5/R6/R7/R8.
        for (int v = 0; v < NV; v++) begin
            int per, e, fw, sw;
            per = 16 * V_M[v];
            use_sector = (V_SRC[v] != 0);
            pole_code  = 2'(V_POLE[v]);
            ref_word_n = ~14'(V_M[v]);
            zc_flag = 1'b0;
            sector_in = 1'b0;
            do_reset();
            if (V_SRC[v] == 0) begin
                e = 2 * rev_toggles(V_POLE[v]) * V_K[v];
                zc_burst(2 * rev_toggles(V_POLE[v]), 1);
                zc_burst(2 * rev_toggles(V_POLE[v]), V_K[v]);
            end else begin
                e = V_K[v];
                sector_in = 1'b1;
                repeat (3) tick();
                sector_in = 1'b0;
                sector_fall_after(e);
            end
            fw = (e < per) ? per - e : 0;
            sw = (e > per) ? e - per : 0;
            repeat (fw + 6) tick();
            check($sformatf("R5 fast width v%0d", v), cnt_fast, fw);
            check($sformatf("R6 slow width v%0d", v), cnt_slow, sw);
            check($sformatf("R7 pullup v%0d", v), pullup_req, (fw > 0) ? 0 : 1);
        end

        // R8: sector source selected, zero-crossing toggles start nothing.
        use_sector = 1'b1;
        ref_word_n = ~14'd4;
        do_reset();
        zc_burst(200, 1);
        check("R8 zc ignored sync", sync_status, 0);
        check("R8 zc ignored pullup", pullup_req, 1);

        // R9 and R4: deferred source change.
        use_sector = 1'b0;
        pole_code  = 2'b01;
        ref_word_n = ~14'd20;
        do_reset();
        check("R4 sync before first edge", sync_status, 0);
        zc_burst(24, 1);
        tick();
        check("R4 sync after edge", sync_status, 1);
        use_sector = 1'b1;
        sector_in = 1'b1;
        repeat (3) tick();
        sector_in = 1'b0;
        repeat (5) tick();
        check("R9 sector edge ignored sync", sync_status, 1);
        check("R9 sector edge ignored fast", cnt_fast, 0);
        repeat (330) tick();
        check("R4 sync low after expiry", sync_status, 0);
        check("R6 slow after expiry", err_slow, 1);
        sector_in = 1'b1;
        repeat (3) tick();
        sector_in = 1'b0;
        repeat (4) tick();
        check("R9 switched source restarts", sync_status, 1);
        check("R9 slow ended", err_slow, 0);

        // R10: external speed control silences errors, pull-up still released.
        use_sector = 1'b0;
        ext_speed  = 1'b1;
        zc_flag    = 1'b0;
        pole_code  = 2'b01;
        ref_word_n = ~14'd10;
        do_reset();
        zc_burst(24, 1);
        zc_burst(24, 4);
        repeat (300) tick();
        check("R10 fast silent", cnt_fast, 0);
        check("R10 slow silent", cnt_slow, 0);
        check("R10 pullup released", pullup_req, 0);
        ext_speed = 1'b0;

        // R11: reset mid-activity.
        do_reset();
        check("R11 reset pullup", pullup_req, 1);
        check("R11 reset sync", sync_status, 0);
        check("R11 reset slow", err_slow, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule